// File: doc/BRIEF.md
# DMA Channel Status, Interrupt and Abort Controller

This block is the global control plane of a multichannel DMA engine. It sits behind a simple 32-bit register bus and keeps, for each channel, an enable bit and three interrupt mask bits. It also keeps three sticky per-channel status vectors: terminal count, abort and error. The datapath reports channel completion, abort-taken and error events as single-cycle pulses. The block latches these events, drops the channel's enable bit and drives one combined interrupt line.

Software starts a channel by writing its configuration word with the enable bit set. It can ask a running channel to abort, and the block passes that request to the datapath as a one-cycle pulse. A software reset write clears every enable bit at once and sends a one-cycle reset pulse to the core. Software services interrupts by reading the packed status word and writing ones back to the bits it has handled.

The register bus is write-strobed and reads are combinational. Address bits [1:0] are ignored. The word map is: control at 0x00, abort at 0x04, status at 0x08, enable mirror at 0x0C, and channel n's configuration at 0x10 + 4·n. The control and abort registers read as zero.

Top module: `dmac_status_ctl`

## Requirements
- R1: After reset every enable, mask and status bit is 0, `irq_o`, `abort_req_o`, `core_rst_o` and `ch_en_o` are 0, and every register reads 0.
- R2: A write to channel n's configuration word stores bit 0 as the enable, bit 1 as the terminal-count mask, bit 2 as the error mask and bit 3 as the abort mask. The word reads back those four bits with all upper bits 0.
- R3: A done pulse sets the channel's terminal-count status only when neither an abort nor an error pulse arrives for that channel in the same cycle. Abort and error pulses set their own status bits.
- R4: Writing 1 to bit n of the abort register gives a one-cycle `abort_req_o[n]` pulse on the cycle after the write, but only if channel n is enabled. For a disabled channel the bit is ignored. An abort request does not by itself clear the enable.
- R5: Writing 1 to bit 0 of the control register clears all enable bits at the write edge and pulses `core_rst_o` for one cycle after it. Masks and status are kept. Writing 0 has no effect.
- R6: The status word holds terminal count in [23:16], abort in [15:8] and error in [7:0], with bit n belonging to channel n. Writing 1 to a bit clears it, and bits written 0 are unchanged.
- R7: The enable mirror word shows bit n equal to channel n's enable. Writes to it are ignored.
- R8: Any done, abort or error pulse clears the channel's enable at the same edge that sets its status.
- R9: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq_o` is the OR over all channels and kinds of status AND NOT mask. Status bits still latch while masked.
- R11: `ch_en_o` always equals the enable vector shown in the mirror word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ev_done | input | 8 | Per-channel completion pulses |
| ev_abort | input | 8 | Per-channel abort-taken pulses |
| ev_err | input | 8 | Per-channel error pulses |
| ch_en_o | output | 8 | Per-channel enable to the datapath |
| abort_req_o | output | 8 | Per-channel abort request pulses |
| core_rst_o | output | 1 | One-cycle software reset pulse to the core |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the collision of an event pulse with a write-one-to-clear on the same status bit. In the same cycle, other bits must be cleared while untouched bits hold their value. The bench drives the status write strobe and the event vectors on one falling edge, so the same rising edge sees both. Some bits receive only the clear, some receive both, and the packed word that results is checked. All three event kinds, in every combination on every channel, are also swept against a model of the status word.

// File: rtl/dmac_sc_pkg.sv
// Package: shared word indices, bit positions and the per-channel
// configuration record for the DMA status/abort controller.
package dmac_sc_pkg;

    // Word indices (byte address >> 2) of the global registers.
    localparam int WI_CTRL   = 0;
    localparam int WI_ABORT  = 1;
    localparam int WI_STAT   = 2;
    localparam int WI_ENMIR  = 3;
    localparam int WI_CFG0   = 4;

    // Field positions inside the packed status word.
    localparam int ST_TC_LSB = 16;
    localparam int ST_AB_LSB = 8;
    localparam int ST_ER_LSB = 0;

    // Per-channel configuration word, bit 3 down to bit 0.
    typedef struct packed {
        logic m_ab;   // bit 3: abort interrupt mask
        logic m_err;  // bit 2: error interrupt mask
        logic m_tc;   // bit 1: terminal-count interrupt mask
        logic en;     // bit 0: channel enable
    } cfg_t;

endpackage

// File: rtl/dmac_sc_decode.sv
// Module: dmac_sc_decode
// Turns a register bus write into one-cycle write strobes per register.
// Assumes word-aligned accesses; address bits [1:0] are ignored.
module dmac_sc_decode
    import dmac_sc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 8
) (
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [ADDR_W-3:0]   widx,
    output logic                ctrl_we,
    output logic                abort_we,
    output logic                stat_we,
    output logic [NUM_CH-1:0]   cfg_we
);
    localparam int WIDX_W = ADDR_W - 2;

    // Word index of the access.
    assign widx = bus_addr[ADDR_W-1:2];

    // Strobes for the global registers.
    assign ctrl_we  = bus_we && (widx == WIDX_W'(WI_CTRL));
    assign abort_we = bus_we && (widx == WIDX_W'(WI_ABORT));
    assign stat_we  = bus_we && (widx == WIDX_W'(WI_STAT));

    // One configuration strobe per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg_we
        assign cfg_we[g] = bus_we && (widx == WIDX_W'(WI_CFG0 + g));
    end

    logic unused_addr_lsb;
    assign unused_addr_lsb = ^bus_addr[1:0];

endmodule

// File: rtl/dmac_sc_chan.sv
// Module: dmac_sc_chan
// State of one DMA channel: enable, three interrupt masks, three sticky
// status bits and the registered abort request. Assumes event pulses last
// one cycle. Set of a status bit wins over a same-cycle clear.
module dmac_sc_chan
    import dmac_sc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_rst,
    input  logic  cfg_we,
    input  cfg_t  cfg_wdata,
    input  logic  abort_hit,
    input  logic  clr_tc,
    input  logic  clr_ab,
    input  logic  clr_er,
    input  logic  ev_done,
    input  logic  ev_abort,
    input  logic  ev_err,
    output cfg_t  cfg_q,
    output logic  st_tc,
    output logic  st_ab,
    output logic  st_er,
    output logic  abort_req
);
    logic term_ev;
    logic clean_done;

    // A channel terminates on any of its three events.
    assign term_ev    = ev_done || ev_abort || ev_err;
    // Completion counts only without a simultaneous abort or error.
    assign clean_done = ev_done && !ev_abort && !ev_err;

    // Enable bit: reset and termination beat a software write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg_q.en <= 1'b0;
        end else if (term_ev) begin
            cfg_q.en <= 1'b0;
        end else if (cfg_we) begin
            cfg_q.en <= cfg_wdata.en;
        end
    end

    // Interrupt masks: written by software only, kept over a soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.m_ab  <= 1'b0;
            cfg_q.m_err <= 1'b0;
            cfg_q.m_tc  <= 1'b0;
        end else if (cfg_we) begin
            cfg_q.m_ab  <= cfg_wdata.m_ab;
            cfg_q.m_err <= cfg_wdata.m_err;
            cfg_q.m_tc  <= cfg_wdata.m_tc;
        end
    end

    // Sticky status bits, set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_tc <= 1'b0;
            st_ab <= 1'b0;
            st_er <= 1'b0;
        end else begin
            st_tc <= clean_done || (st_tc && !clr_tc);
            st_ab <= ev_abort   || (st_ab && !clr_ab);
            st_er <= ev_err     || (st_er && !clr_er);
        end
    end

    // Abort request pulse, issued only for an enabled channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_req <= 1'b0;
        end else begin
            abort_req <= abort_hit && cfg_q.en;
        end
    end

    // R3: a clean completion is always recorded.
    p_tc_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && !ev_abort && !ev_err) |=> st_tc);

    // R3: an abort or error in the same cycle keeps terminal count clear.
    p_tc_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_tc && ev_done && (ev_abort || ev_err)) |=> !st_tc);

    // R4: an abort request only leaves for a channel that was enabled.
    p_abort_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> $past(cfg_q.en));

    // R5: software reset drops the enable.
    p_soft_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !cfg_q.en);

    // R8: any terminating event drops the enable.
    p_term_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        term_ev |=> !cfg_q.en);

    // R9: event set beats a same-cycle clear.
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err && clr_er) |=> st_er);

    // R10: status stays latched without a clear, whatever the mask.
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ab && !clr_ab) |=> st_ab);

endmodule

// File: rtl/dmac_sc_rdmux.sv
// Module: dmac_sc_rdmux
// Combinational read multiplexer for the register bus. Assumes
// NUM_CH <= 8 so each status field fits its byte lane.
module dmac_sc_rdmux
    import dmac_sc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 8
) (
    input  logic [ADDR_W-3:0]  widx,
    input  cfg_t               cfg [NUM_CH],
    input  logic [NUM_CH-1:0]  en_v,
    input  logic [NUM_CH-1:0]  tc_v,
    input  logic [NUM_CH-1:0]  ab_v,
    input  logic [NUM_CH-1:0]  er_v,
    output logic [31:0]        rdata
);
    localparam int WIDX_W = ADDR_W - 2;

    // Select the addressed word; unmapped and write-only words read 0.
    always_comb begin
        rdata = '0;
        if (widx == WIDX_W'(WI_STAT)) begin
            rdata[ST_TC_LSB +: NUM_CH] = tc_v;
            rdata[ST_AB_LSB +: NUM_CH] = ab_v;
            rdata[ST_ER_LSB +: NUM_CH] = er_v;
        end else if (widx == WIDX_W'(WI_ENMIR)) begin
            rdata[NUM_CH-1:0] = en_v;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (widx == WIDX_W'(WI_CFG0 + i)) begin
                rdata[$bits(cfg_t)-1:0] = cfg[i];
            end
        end
    end

endmodule

// File: rtl/dmac_status_ctl.sv
// Module: dmac_status_ctl (top)
// Global control and interrupt status for a multichannel DMA engine:
// per-channel enables and masks, abort requests, software reset, three
// write-one-to-clear status vectors and one combined interrupt.
// Assumes a synchronous active-low reset and NUM_CH <= 8.
module dmac_status_ctl
    import dmac_sc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_CH-1:0]  ev_done,
    input  logic [NUM_CH-1:0]  ev_abort,
    input  logic [NUM_CH-1:0]  ev_err,
    output logic [NUM_CH-1:0]  ch_en_o,
    output logic [NUM_CH-1:0]  abort_req_o,
    output logic               core_rst_o,
    output logic               irq_o
);
    logic [ADDR_W-3:0]  widx;
    logic               ctrl_we;
    logic               abort_we;
    logic               stat_we;
    logic [NUM_CH-1:0]  cfg_we;
    logic               soft_rst;
    cfg_t               cfg [NUM_CH];
    logic [NUM_CH-1:0]  en_v, mtc_v, merr_v, mab_v;
    logic [NUM_CH-1:0]  tc_v, ab_v, er_v;

    dmac_sc_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .widx     (widx),
        .ctrl_we  (ctrl_we),
        .abort_we (abort_we),
        .stat_we  (stat_we),
        .cfg_we   (cfg_we)
    );

    // Software reset is bit 0 of a control-register write.
    assign soft_rst = ctrl_we && bus_wdata[0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dmac_sc_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst),
            .cfg_we    (cfg_we[g]),
            .cfg_wdata (cfg_t'(bus_wdata[$bits(cfg_t)-1:0])),
            .abort_hit (abort_we && bus_wdata[g]),
            .clr_tc    (stat_we && bus_wdata[ST_TC_LSB + g]),
            .clr_ab    (stat_we && bus_wdata[ST_AB_LSB + g]),
            .clr_er    (stat_we && bus_wdata[ST_ER_LSB + g]),
            .ev_done   (ev_done[g]),
            .ev_abort  (ev_abort[g]),
            .ev_err    (ev_err[g]),
            .cfg_q     (cfg[g]),
            .st_tc     (tc_v[g]),
            .st_ab     (ab_v[g]),
            .st_er     (er_v[g]),
            .abort_req (abort_req_o[g])
        );
        assign en_v[g]   = cfg[g].en;
        assign mtc_v[g]  = cfg[g].m_tc;
        assign merr_v[g] = cfg[g].m_err;
        assign mab_v[g]  = cfg[g].m_ab;
    end

    dmac_sc_rdmux #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_rdmux (
        .widx  (widx),
        .cfg   (cfg),
        .en_v  (en_v),
        .tc_v  (tc_v),
        .ab_v  (ab_v),
        .er_v  (er_v),
        .rdata (bus_rdata)
    );

    // One-cycle reset pulse to the core after a software reset write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rst_o <= 1'b0;
        end else begin
            core_rst_o <= soft_rst;
        end
    end

    // Enables go straight to the datapath.
    assign ch_en_o = en_v;

    // Combined interrupt: any unmasked status bit.
    assign irq_o = |((tc_v & ~mtc_v) | (ab_v & ~mab_v) | (er_v & ~merr_v));

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    // R5: the core reset pulse lasts one cycle.
    p_core_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o || $past(soft_rst));

    // R10: an unmasked error status always raises the interrupt.
    p_irq_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(er_v & ~merr_v)) |-> irq_o);

endmodule

// File: tb/test_dmac_status_ctl.sv
module test_dmac_status_ctl;

    localparam int NCH = 8;
    localparam logic [7:0] A_CTRL = 8'h00, A_ABT = 8'h04, A_STAT = 8'h08,
                           A_MIR = 8'h0C, A_CFG0 = 8'h10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  ev_done = '0, ev_abort = '0, ev_err = '0;
    logic [NCH-1:0]  ch_en_o, abort_req_o;
    logic            core_rst_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dmac_status_ctl i_dmac_status_ctl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
        .ev_abort(ev_abort), .ev_err(ev_err), .ch_en_o(ch_en_o),
        .abort_req_o(abort_req_o), .core_rst_o(core_rst_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ev(input logic [NCH-1:0] d, input logic [NCH-1:0] a, input logic [NCH-1:0] e);
        @(negedge clk);
        ev_done = d; ev_abort = a; ev_err = e;
        @(negedge clk);
        ev_done = '0; ev_abort = '0; ev_err = '0;
    endtask

    function automatic logic [31:0] stw(input logic [7:0] t, input logic [7:0] a, input logic [7:0] e);
        return {8'h00, t, a, e};
    endfunction

    initial begin : watchdog
        #(20ns * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of outputs and every register.
        chk("R1 outputs", {ch_en_o, abort_req_o, 14'b0, core_rst_o, irq_o}, '0);
        for (int a = 0; a < 12; a++) begin
            rd(8'(a * 4), r);
            chk("R1 read", r, '0);
        end

        // R2: config write/readback sweep, R7/R11 mirror of enable.
        for (int ch = 0; ch < NCH; ch++) begin
            for (int v = 0; v < 16; v++) begin
                wr(A_CFG0 + 8'(ch * 4), 32'hFFFF_FFF0 | 32'(v));
                rd(A_CFG0 + 8'(ch * 4), r);
                chk("R2 cfg readback", r, 32'(v));
                rd(A_MIR, r);
                chk("R7 mirror", r, 32'(v & 1) << ch);
                chk("R11 ch_en_o", 32'(ch_en_o), 32'(v & 1) << ch);
            end
            wr(A_CFG0 + 8'(ch * 4), 0);
        end

        // R3/R8: every event combination on every channel.
        for (int ch = 0; ch < NCH; ch++) begin
            for (int c = 1; c < 8; c++) begin
                logic d, ab, e;
                d = c[0]; ab = c[1]; e = c[2];
                wr(A_CFG0 + 8'(ch * 4), 1);
                ev(8'(d) << ch, 8'(ab) << ch, 8'(e) << ch);
                rd(A_STAT, r);
                chk("R3 status", r, stw(8'(d & !ab & !e) << ch, 8'(ab) << ch, 8'(e) << ch));
                chk("R8 enable dropped", 32'(ch_en_o), 0);
                wr(A_STAT, 32'h00FF_FFFF);
            end
        end

        // R4: abort honoured only for the enabled channel.
        for (int ch = 0; ch < NCH; ch++) begin
            wr(A_CFG0 + 8'(ch * 4), 1);
            wr(A_ABT, 32'hFF);
            chk("R4 abort pulse", 32'(abort_req_o), 32'(1) << ch);
            @(negedge clk);
            chk("R4 pulse ends", 32'(abort_req_o), 0);
            chk("R4 enable kept", 32'(ch_en_o), 32'(1) << ch);
            wr(A_CFG0 + 8'(ch * 4), 0);
            wr(A_ABT, 32'(1) << ch);
            chk("R4 disabled ignored", 32'(abort_req_o), 0);
        end

        // R7: writes to the mirror have no effect.
        wr(A_CFG0 + 8'd8, 1);
        wr(A_MIR, 32'hFF);
        rd(A_MIR, r);
        chk("R7 mirror write ignored", r, 32'h04);

        // R5: software reset.
        for (int ch = 0; ch < NCH; ch++) wr(A_CFG0 + 8'(ch * 4), 32'hF);
        ev(8'h00, 8'h00, 8'h00);
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_MIR, r);
        chk("R5 write 0 no effect", {r[7:0], 7'b0, core_rst_o}, {8'hFF, 8'h00});
        wr(A_CTRL, 1);
        chk("R5 core reset pulse", 32'(core_rst_o), 1);
        chk("R5 enables cleared", 32'(ch_en_o), 0);
        @(negedge clk);
        chk("R5 pulse ends", 32'(core_rst_o), 0);
        rd(A_CFG0 + 8'd12, r);
        chk("R5 masks kept", r, 32'hE);
        for (int ch = 0; ch < NCH; ch++) wr(A_CFG0 + 8'(ch * 4), 0);

        // R6: layout and partial write-one-to-clear.
        ev(8'h0F, 8'h00, 8'h00);
        ev(8'h00, 8'h30, 8'h00);
        ev(8'h00, 8'h00, 8'hC0);
        rd(A_STAT, r);
        chk("R6 layout", r, stw(8'h0F, 8'h30, 8'hC0));
        wr(A_STAT, stw(8'h05, 8'h10, 8'h00));
        rd(A_STAT, r);
        chk("R6 partial clear", r, stw(8'h0A, 8'h20, 8'hC0));
        wr(A_STAT, 0);
        rd(A_STAT, r);
        chk("R6 zero write", r, stw(8'h0A, 8'h20, 8'hC0));
        wr(A_STAT, 32'h00FF_FFFF);

        // R9: set and clear in the same cycle.
        ev(8'h00, 8'hFF, 8'h00);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h00FF_FFFF;
        ev_done = 8'hF0; ev_err = 8'h0F;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; ev_done = '0; ev_err = '0;
        rd(A_STAT, r);
        chk("R9 set wins", r, stw(8'hF0, 8'h00, 8'h0F));
        wr(A_STAT, 32'h00FF_FFFF);

        // R10: interrupt per channel, kind and mask.
        for (int ch = 0; ch < NCH; ch++) begin
            for (int k = 0; k < 3; k++) begin
                for (int m = 0; m < 2; m++) begin
                    int mbit;
                    mbit = (k == 0) ? 1 : (k == 1) ? 3 : 2;
                    wr(A_CFG0 + 8'(ch * 4), 32'(m) << mbit);
                    ev(8'(k == 0) << ch, 8'(k == 1) << ch, 8'(k == 2) << ch);
                    chk("R10 irq", 32'(irq_o), 32'(m == 0));
                    rd(A_STAT, r);
                    chk("R10 latched", r, stw(8'(k == 0) << ch, 8'(k == 1) << ch, 8'(k == 2) << ch));
                    wr(A_STAT, 32'h00FF_FFFF);
                    chk("R10 irq cleared", 32'(irq_o), 0);
                end
            end
            wr(A_CFG0 + 8'(ch * 4), 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule